// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a supervisory counter for a small controller. A prescaler divides the system clock into quarter-second units. Once software arms the block, it counts these units. If software does not restart the count within the programmed number of units, the block drives a device reset request for a fixed number of clock cycles. After that pulse the block returns to the disarmed state, which is also its state after power-on reset.

Software reaches the block through one write-only control register on a simple byte write port. The register holds an arm bit, a restart bit and a 3-bit interval code. The interval code selects 1 to 8 units, and code 000 selects the longest interval. The prescale ratio, the pulse length, the register address and the bit positions are parameters.

Top module: `wdog_top`

## Requirements
- R1: After `rst_n` is low, the block is disarmed and `wdt_rst` is low. No pulse ever occurs without an arming write.
- R2: A write to address `CTRL_ADDR` (0x18) with bit 7 set arms the block and takes the interval code from bits 2:0. Code values 1 to 7 give N equal to the code. `wdt_rst` first goes high after the clock edge that lies N×`TICK_DIV` edges after the edge that accepted the arming write.
- R3: Interval code 000 gives N = 8, which is the longest interval.
- R4: While the block is armed, a write to `CTRL_ADDR` with bit 6 set restarts the count from zero. The next pulse then starts N×`TICK_DIV` edges after that write's edge. Bit 6 does not stay set and has no later effect.
- R5: While the block is armed, a write to `CTRL_ADDR` with bit 7 clear does not disarm it. Only reset or a completed pulse returns the block to the disarmed state.
- R6: Writes to any other address, and cycles with `wr_en` low, have no effect on the block.
- R7: Each pulse on `wdt_rst` stays high for exactly `PULSE_CYC` consecutive cycles.
- R8: After a pulse the block is disarmed and gives no further pulse until a new arming write.
- R9: A restart write while the block is disarmed has no effect. An arming write that is accepted while the pulse is active is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the prescaler divides it into units |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Write data: bit 7 arm, bit 6 restart, bits 2:0 interval code |
| wdt_rst | output | 1 | Device reset request pulse, active high |

## Verification
The block has only one output pin, so every wrong internal state appears as a change in timing on `wdt_rst`. A prescaler or unit counter that is off by one moves the rising edge by at least one cycle. A wrong decode of the interval code moves it by a whole multiple of `TICK_DIV`. A restart that is missed or that has no effect fires the pulse too early or too late, within at most eight units of the write. A wrong pulse counter changes the pulse width within `PULSE_CYC` cycles. A block that stays armed after a pulse gives a second pulse within eight units.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

   typedef enum logic [1:0] {
      WD_OFF  = 2'd0,
      WD_RUN  = 2'd1,
      WD_FIRE = 2'd2
   } wd_state_t;

   // number of units selected by an interval code; code 0 means the maximum
   function automatic int unsigned wd_units(input int unsigned code, input int unsigned code_w);
      return (code == 0) ? (1 << code_w) : code;
   endfunction

endpackage

// File: rtl/wdog_regif.sv
`timescale 1ns/1ps
module wdog_regif #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 'h18,
   parameter int EN_BIT    = 7,
   parameter int CLR_BIT   = 6,
   parameter int CODE_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              start_req,
   output logic              clr_req,
   output logic [CODE_W-1:0] code_q
);

   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CTRL_ADDR);

   logic hit;
   logic unused_data;

   assign hit         = wr_en && (wr_addr == HIT_ADDR);
   assign start_req   = hit && wr_data[EN_BIT];
   assign clr_req     = hit && wr_data[CLR_BIT];
   assign unused_data = ^wr_data;

   // the interval code follows every write to the control address
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
      end else if (hit) begin
         code_q <= wr_data[CODE_W-1:0];
      end
   end

endmodule

// File: rtl/wdog_tick.sv
`timescale 1ns/1ps
module wdog_tick #(
   parameter int TICK_DIV = 3_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);

   generate
      if (TICK_DIV == 1) begin : g_direct
         logic unused_tick_in;
         assign unused_tick_in = clk ^ rst_n;
         assign tick           = run && !restart;
      end else begin : g_div
         localparam int PRE_W = $clog2(TICK_DIV);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

         logic [PRE_W-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (!run || restart) begin
               pre_q <= '0;
            end else if (pre_q == PRE_LAST) begin
               pre_q <= '0;
            end else begin
               pre_q <= pre_q + 1'b1;
            end
         end

         assign tick = run && !restart && (pre_q == PRE_LAST);
      end
   endgenerate

endmodule

// File: rtl/wdog_count.sv
`timescale 1ns/1ps
module wdog_count #(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic              tick,
   input  logic [CODE_W-1:0] code,
   output logic [CODE_W:0]   units,
   output logic              expire
);

   localparam int UNIT_W = CODE_W + 1;
   localparam logic [UNIT_W-1:0] UNIT_MAX = UNIT_W'(1 << CODE_W);

   logic [UNIT_W-1:0] limit;
   logic [UNIT_W-1:0] units_q;
   logic [UNIT_W-1:0] units_p1;

   assign limit    = (code == '0) ? UNIT_MAX : {1'b0, code};
   assign units_p1 = units_q + UNIT_W'(1);
   // a shortened interval that is already passed fires on the next unit
   assign expire   = run && !restart && tick && (units_p1 >= limit);
   assign units    = units_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         units_q <= '0;
      end else if (!run || restart) begin
         units_q <= '0;
      end else if (tick && !expire) begin
         units_q <= units_p1;
      end
   end

endmodule

// File: rtl/wdog_ctrl.sv
`timescale 1ns/1ps
module wdog_ctrl
   import wdog_pkg::*;
#(
   parameter int PULSE_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic clr_req,
   input  logic expire,
   output logic run,
   output logic restart,
   output logic wdt_rst
);

   localparam int PC_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
   localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSE_CYC - 1);

   wd_state_t       state_q, state_d;
   logic [PC_W-1:0] pcnt_q;

   assign run     = (state_q == WD_RUN);
   assign restart = run && clr_req;
   assign wdt_rst = (state_q == WD_FIRE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         WD_OFF:  if (start_req) state_d = WD_RUN;
         WD_RUN:  if (expire) state_d = WD_FIRE;
         WD_FIRE: if (pcnt_q == PC_LAST) state_d = WD_OFF;
         default: state_d = WD_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WD_OFF;
         pcnt_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == WD_FIRE) begin
            pcnt_q <= pcnt_q + 1'b1;
         end else begin
            pcnt_q <= '0;
         end
      end
   end

endmodule

// File: rtl/wdog_top.sv
`timescale 1ns/1ps
module wdog_top #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 'h18,
   parameter int EN_BIT    = 7,
   parameter int CLR_BIT   = 6,
   parameter int CODE_W    = 3,
   parameter int TICK_DIV  = 3_000_000,
   parameter int PULSE_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wdt_rst
);

   // elaboration-time parameter checks
   if (TICK_DIV < 1) begin : g_bad_div
      $error("wdog_top: TICK_DIV must be at least 1");
   end
   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("wdog_top: PULSE_CYC must be at least 1");
   end
   if (EN_BIT >= DATA_W || CLR_BIT >= DATA_W || EN_BIT == CLR_BIT) begin : g_bad_bits
      $error("wdog_top: control bit positions invalid");
   end
   if (CODE_W < 1 || CODE_W > EN_BIT || CODE_W > CLR_BIT) begin : g_bad_code
      $error("wdog_top: interval code overlaps control bits");
   end
   if (CTRL_ADDR < 0 || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("wdog_top: CTRL_ADDR does not fit ADDR_W");
   end

   logic              start_req;
   logic              clr_req;
   logic [CODE_W-1:0] code_q;
   logic              run;
   logic              restart;
   logic              tick;
   logic              expire;
   logic [CODE_W:0]   units;

   wdog_regif #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CTRL_ADDR(CTRL_ADDR),
      .EN_BIT   (EN_BIT),
      .CLR_BIT  (CLR_BIT),
      .CODE_W   (CODE_W)
   ) u_regif (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .start_req(start_req),
      .clr_req  (clr_req),
      .code_q   (code_q)
   );

   wdog_tick #(
      .TICK_DIV(TICK_DIV)
   ) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .restart(restart),
      .tick   (tick)
   );

   wdog_count #(
      .CODE_W(CODE_W)
   ) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .restart(restart),
      .tick   (tick),
      .code   (code_q),
      .units  (units),
      .expire (expire)
   );

   wdog_ctrl #(
      .PULSE_CYC(PULSE_CYC)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_req(start_req),
      .clr_req  (clr_req),
      .expire   (expire),
      .run      (run),
      .restart  (restart),
      .wdt_rst  (wdt_rst)
   );

endmodule

// File: rtl/wdog_chk.sv
`timescale 1ns/1ps
module wdog_chk #(
   parameter int CODE_W    = 3,
   parameter int TICK_DIV  = 3_000_000,
   parameter int PULSE_CYC = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_req,
   input logic            clr_req,
   input logic            run,
   input logic [CODE_W:0] units,
   input logic            wdt_rst
);

   localparam longint GAP_MAX = longint'(TICK_DIV) << CODE_W;
   localparam int     GAP_W   = $clog2(GAP_MAX + 2) + 1;
   localparam int     HL_W    = $clog2(PULSE_CYC + 2) + 1;

   logic             armed_q;
   logic [GAP_W-1:0] gap_q;
   logic [HL_W-1:0]  hi_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         gap_q    <= '0;
         hi_len_q <= '0;
      end else begin
         if (wdt_rst) begin
            armed_q <= 1'b0;
         end else if (start_req) begin
            armed_q <= 1'b1;
         end
         if ((start_req && !armed_q && !wdt_rst) || (clr_req && armed_q)) begin
            gap_q <= '0;
         end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
         end
         hi_len_q <= wdt_rst ? hi_len_q + 1'b1 : '0;
      end
   end

   AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_rst) |-> armed_q); // R1

   AST_FIRE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_rst) |-> (longint'(gap_q) >= longint'(TICK_DIV) && longint'(gap_q) <= GAP_MAX)); // R2

   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (run && clr_req) |=> (units == '0)); // R4

   AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (run || wdt_rst)); // R5

   AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdt_rst) |-> (int'(hi_len_q) == PULSE_CYC)); // R7

   AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst |-> (int'(hi_len_q) < PULSE_CYC)); // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !wdt_rst) |=> !wdt_rst); // R8

endmodule

bind wdog_top wdog_chk #(
   .CODE_W   (CODE_W),
   .TICK_DIV (TICK_DIV),
   .PULSE_CYC(PULSE_CYC)
) u_wdog_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_req(start_req),
   .clr_req  (clr_req),
   .run      (run),
   .units    (units),
   .wdt_rst  (wdt_rst)
);

// File: tb/test_wdog_top.sv
`timescale 1ns/1ps
module test_wdog_top;

   localparam int TDIV  = 5;
   localparam int PLEN  = 4;
   localparam int CADDR = 'h18;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       wdt_rst;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   int wr_edge = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdog_top #(
      .TICK_DIV (TDIV),
      .PULSE_CYC(PLEN)
   ) i_wdog_top (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .wdt_rst(wdt_rst)
   );

   function automatic int n_of(input int code);
      return (code == 0) ? 8 : code;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_write(input int addr, input int data);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 8'(addr);
      wr_data = 8'(data);
      wr_edge = cyc + 1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_fire(output int edge_no, input int limit);
      edge_no = -1;
      for (int k = 0; k < limit; k++) begin
         @(negedge clk);
         if (wdt_rst) begin
            edge_no = cyc;
            return;
         end
      end
   endtask

   task automatic pulse_width(output int w);
      w = 1;
      while (wdt_rst && w < 100) begin
         @(negedge clk);
         if (wdt_rst) w++;
      end
   endtask

   task automatic quiet_count(input int n, output int highs);
      highs = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (wdt_rst) highs++;
      end
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int f, w, h, base, code, n;
      void'($urandom(32'd4099));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: disarmed after reset
      quiet_count(60, h);
      check(h == 0, "R1 reset quiet", h, 0);

      // R2 / R3 / R7: every interval code
      for (int c = 0; c < 8; c++) begin
         do_write(CADDR, 'h80 | c);
         base = wr_edge;
         wait_fire(f, 100);
         check(f == base + n_of(c) * TDIV, (c == 0) ? "R3 code0 latency" : "R2 latency",
               f - base, n_of(c) * TDIV);
         pulse_width(w);
         check(w == PLEN, "R7 pulse width", w, PLEN);
      end

      // R8: no pulse after a completed one
      quiet_count(60, h);
      check(h == 0, "R8 disarmed after pulse", h, 0);

      // R9: restart write while disarmed
      do_write(CADDR, 'h40 | 3);
      quiet_count(60, h);
      check(h == 0, "R9 restart while off", h, 0);

      // R6: arming write to another address, and arm bit with wr_en low
      do_write(CADDR + 1, 'hC7);
      @(negedge clk);
      wr_addr = 8'(CADDR);
      wr_data = 8'h81;
      quiet_count(60, h);
      check(h == 0, "R6 foreign address and strobe low", h, 0);

      // R4: restart mid-run
      do_write(CADDR, 'h82);
      repeat (7) @(negedge clk);
      do_write(CADDR, 'h42);
      base = wr_edge;
      wait_fire(f, 100);
      check(f == base + 2 * TDIV, "R4 restart latency", f - base, 2 * TDIV);
      pulse_width(w);

      // R5: write with arm bit clear does not stop the count
      do_write(CADDR, 'h84);
      base = wr_edge;
      repeat (5) @(negedge clk);
      do_write(CADDR, 'h04);
      wait_fire(f, 100);
      check(f == base + 4 * TDIV, "R5 keeps running", f - base, 4 * TDIV);
      pulse_width(w);

      // R9: arming write during the pulse is ignored
      do_write(CADDR, 'h81);
      wait_fire(f, 100);
      do_write(CADDR, 'h81);
      pulse_width(w);
      quiet_count(60, h);
      check(h == 0, "R9 arm during pulse ignored", h, 0);

      // random mix: restarts, foreign writes, arm-clear writes (R2 R4 R5 R6 R7)
      for (int it = 0; it < 25; it++) begin
         code = int'($urandom % 8);
         n    = n_of(code);
         do_write(CADDR, 'h80 | code);
         base = wr_edge;
         for (int a = 0; a < 4; a++) begin
            int room, d, act;
            room = base + n * TDIV - cyc - 1;
            if (room <= 1) break;
            d   = int'($urandom % (room - 1));
            act = int'($urandom % 3);
            repeat (d) @(negedge clk);
            if (act == 0) begin
               do_write(CADDR, 'h40 | code);
               base = wr_edge;
            end else if (act == 1) begin
               do_write(CADDR ^ (1 + int'($urandom % 255)), int'($urandom % 256));
            end else begin
               do_write(CADDR, code);
            end
         end
         wait_fire(f, 200);
         check(f == base + n * TDIV, "R2 R4 random latency", f - base, n * TDIV);
         pulse_width(w);
         check(w == PLEN, "R7 random width", w, PLEN);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule